// File: doc/BRIEF.md
# Paired Direction-Swappable Byte Queues

This block holds two independent byte queues, each four entries deep, between a system bus and an internal datapath. A per-queue direction input decides which side writes and which side reads. In the "toward datapath" direction the bus fills the queue and the datapath drains it. In the "toward bus" direction the datapath fills it and the bus drains it. Because each queue is steered on its own, the two can be set the same way for dual capture or double buffering, or opposite ways for a transmit/receive pair.

Each queue runs a three-state fill controller. FS_EMPTY goes to FS_PARTIAL on an accepted write. FS_PARTIAL goes to FS_FULL when a lone write lands on the last free slot, and back to FS_EMPTY when a lone read takes the last entry. FS_FULL goes to FS_PARTIAL on a read. A direction change (flush) forces FS_EMPTY from any state. Each queue reports empty, full, its entry count, a "has data" flag and a "has room" flag for interrupt, DMA or sequencer logic. A per-queue level select sets the threshold for those two flags. Sticky overflow and underflow flags record misuse.

Read data is registered. The read port of the side that is not the reader shows zero.

Top module: `dual_dir_byte_fifo`

## Requirements
- R1: After reset every queue is empty (empty=1, full=0, count=0), both sticky flags are 0, both read data ports are 0, and the direction is "toward datapath" (encoding 0).
- R2: With direction 0, a bus write strobe stores a byte and a datapath read strobe returns bytes on the datapath read port in write order. In this direction the datapath write strobe and the bus read strobe have no effect.
- R3: With direction 1, a datapath write strobe stores a byte and a bus read strobe returns bytes on the bus read port in write order. In this direction the bus write strobe and the datapath read strobe have no effect.
- R4: Count is the number of stored bytes. Full is 1 exactly when count is 4, and empty is 1 exactly when count is 0.
- R5: A write while full is dropped: contents and count are unchanged, and the overflow flag becomes 1 and stays 1 until reset.
- R6: A read while empty leaves the read data at its previous value and sets the underflow flag, which stays 1 until reset.
- R7: A read and a write in the same cycle, while neither empty nor full, leave the count unchanged and keep first-in first-out order.
- R8: A read and a write in the same cycle while full perform the read and drop the write, setting overflow (count 3). While empty, they perform the write and flag an underflow (count 1).
- R9: With level select 0, "has data" means count ≥ 1 and "has room" means free slots ≥ 1. With level select 1, both thresholds become 2 (half of the depth).
- R10: When a direction input differs from the queue's current direction, the next edge empties that queue, clears its read data, adopts the new direction and ignores any strobe in that cycle. The sticky flags are kept.
- R11: The two queues are independent: strobes, direction and level select of one never change the outputs of the other.
- R12: The read data port on the non-reading side is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dir | input | 2 | Per-queue direction: 0 = bus to datapath, 1 = datapath to bus |
| cfg_half | input | 2 | Per-queue level select for the has-data / has-room flags |
| bus_wr | input | 2 | Bus write strobe per queue |
| bus_wdata | input | 16 | Bus write byte per queue (queue n in bits 8n+7:8n) |
| bus_rd | input | 2 | Bus read strobe per queue |
| bus_rdata | output | 16 | Bus read byte per queue |
| dp_wr | input | 2 | Datapath write strobe per queue |
| dp_wdata | input | 16 | Datapath write byte per queue |
| dp_rd | input | 2 | Datapath read strobe per queue |
| dp_rdata | output | 16 | Datapath read byte per queue |
| q_empty | output | 2 | Queue holds no bytes |
| q_full | output | 2 | Queue holds four bytes |
| q_has_data | output | 2 | Count reaches the selected threshold |
| q_has_room | output | 2 | Free slots reach the selected threshold |
| q_count | output | 6 | Entry count per queue (3 bits each) |
| q_overflow | output | 2 | Sticky write-while-full flag |
| q_underflow | output | 2 | Sticky read-while-empty flag |

## Verification
Every strobe and every direction change is sampled at a rising edge. Its effect on count, empty, full, the sticky flags and the registered read data is visible right after that same edge, so it is due one edge after the inputs are applied. The has-data and has-room flags are combinational from the count and so appear in that same cycle. The bench drives inputs at the falling edge and steps its reference model at the following rising edge. It compares every output at the next falling edge, which is half a cycle after the result is due and before the next stimulus lands.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;

    typedef enum logic [1:0] {
        FS_EMPTY   = 2'd0,
        FS_PARTIAL = 2'd1,
        FS_FULL    = 2'd2
    } fill_state_e;

    typedef enum logic {
        DIR_TO_DP  = 1'b0,
        DIR_TO_BUS = 1'b1
    } lane_dir_e;

endpackage

// File: rtl/dir_port_mux.sv
module dir_port_mux
    import fifo_pair_pkg::*;
#(
    parameter int DW = 8
) (
    input  lane_dir_e         dir,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_rd,
    input  logic              dp_wr,
    input  logic [DW-1:0]     dp_wdata,
    input  logic              dp_rd,
    input  logic [DW-1:0]     q_rdata,
    output logic              q_wr,
    output logic [DW-1:0]     q_wdata,
    output logic              q_rd,
    output logic [DW-1:0]     bus_rdata,
    output logic [DW-1:0]     dp_rdata
);

    always_comb begin
        unique case (dir)
            DIR_TO_DP: begin
                q_wr      = bus_wr;
                q_wdata   = bus_wdata;
                q_rd      = dp_rd;
                bus_rdata = '0;
                dp_rdata  = q_rdata;
            end
            DIR_TO_BUS: begin
                q_wr      = dp_wr;
                q_wdata   = dp_wdata;
                q_rd      = bus_rd;
                bus_rdata = q_rdata;
                dp_rdata  = '0;
            end
            default: begin
                q_wr      = 1'b0;
                q_wdata   = '0;
                q_rd      = 1'b0;
                bus_rdata = '0;
                dp_rdata  = '0;
            end
        endcase
    end

endmodule

// File: rtl/fifo_core.sv
module fifo_core
    import fifo_pair_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_dir,
    input  logic                          wr,
    input  logic [DW-1:0]                 wdata,
    input  logic                          rd,
    output lane_dir_e                     dir_q,
    output logic [DW-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]    cnt,
    output logic                          is_empty,
    output logic                          is_full,
    output logic                          ovf,
    output logic                          unf
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_TOP  = CW'(DEPTH);

    fill_state_e       state_q, state_nxt;
    logic [DW-1:0]     mem [DEPTH];
    logic [PW-1:0]     wptr_q, rptr_q;
    logic [CW-1:0]     cnt_q, cnt_nxt;
    logic [DW-1:0]     rdata_q;
    logic              ovf_q, unf_q;
    logic              flush, wr_go, rd_go;

    assign flush = (cfg_dir != logic'(dir_q));
    assign wr_go = wr && !flush && (state_q != FS_FULL);
    assign rd_go = rd && !flush && (state_q != FS_EMPTY);

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            FS_EMPTY: begin
                if (wr_go)
                    state_nxt = (DEPTH == 1) ? FS_FULL : FS_PARTIAL;
            end
            FS_PARTIAL: begin
                if (wr_go && !rd_go && cnt_q == CW'(DEPTH - 1))
                    state_nxt = FS_FULL;
                else if (rd_go && !wr_go && cnt_q == CW'(1))
                    state_nxt = FS_EMPTY;
            end
            FS_FULL: begin
                if (rd_go)
                    state_nxt = (DEPTH == 1) ? FS_EMPTY : FS_PARTIAL;
            end
            default: state_nxt = FS_EMPTY;
        endcase
        if (flush)
            state_nxt = FS_EMPTY;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_EMPTY;
        else        state_q <= state_nxt;
    end

    always_comb begin
        unique case ({wr_go, rd_go})
            2'b10:   cnt_nxt = cnt_q + CW'(1);
            2'b01:   cnt_nxt = cnt_q - CW'(1);
            default: cnt_nxt = cnt_q;
        endcase
        if (flush)
            cnt_nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (wr_go)
            mem[wptr_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= DIR_TO_DP;
            wptr_q  <= '0;
            rptr_q  <= '0;
            cnt_q   <= '0;
            rdata_q <= '0;
            ovf_q   <= 1'b0;
            unf_q   <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            if (flush) begin
                dir_q   <= lane_dir_e'(cfg_dir);
                wptr_q  <= '0;
                rptr_q  <= '0;
                rdata_q <= '0;
            end else begin
                if (wr_go)
                    wptr_q <= (wptr_q == PTR_LAST) ? '0 : wptr_q + PW'(1);
                if (rd_go) begin
                    rdata_q <= mem[rptr_q];
                    rptr_q  <= (rptr_q == PTR_LAST) ? '0 : rptr_q + PW'(1);
                end
                if (wr && state_q == FS_FULL)
                    ovf_q <= 1'b1;
                if (rd && state_q == FS_EMPTY)
                    unf_q <= 1'b1;
            end
        end
    end

    // output process
    always_comb begin
        is_empty = (state_q == FS_EMPTY);
        is_full  = (state_q == FS_FULL);
        cnt      = cnt_q;
        rdata    = rdata_q;
        ovf      = ovf_q;
        unf      = unf_q;
    end

    p_empty_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_EMPTY) == (cnt_q == '0));

    p_full_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_FULL) == (cnt_q == CNT_TOP));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !rd && !flush && state_q == FS_FULL) |=> (cnt_q == CNT_TOP && ovf_q));

    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    p_unf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !flush && state_q == FS_EMPTY) |=> ($stable(rdata_q) && unf_q));

    p_rw_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && rd && !flush && state_q == FS_PARTIAL) |=> $stable(cnt_q));

    p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt_q == '0 && state_q == FS_EMPTY && rdata_q == '0));

endmodule

// File: rtl/fifo_level_status.sv
module fifo_level_status #(
    parameter int DEPTH = 4
) (
    input  logic [$clog2(DEPTH+1)-1:0] cnt,
    input  logic                       half,
    output logic                       has_data,
    output logic                       has_room
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int HALF_RAW = DEPTH / 2;
    localparam logic [CW-1:0] THR_HALF = CW'((HALF_RAW < 1) ? 1 : HALF_RAW);

    logic [CW-1:0] thr;
    logic [CW-1:0] free_slots;

    always_comb begin
        thr        = half ? THR_HALF : CW'(1);
        free_slots = CW'(DEPTH) - cnt;
        has_data   = (cnt >= thr);
        has_room   = (free_slots >= thr);
    end

    always_comb begin
        p_data_needs_entry_r9: assert (!(has_data && cnt == '0));
        p_room_needs_slot_r9:  assert (!(has_room && cnt == CW'(DEPTH)));
    end

endmodule

// File: rtl/dual_dir_byte_fifo.sv
module dual_dir_byte_fifo
    import fifo_pair_pkg::*;
#(
    parameter int NUM_Q = 2,
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_Q-1:0]                   cfg_dir,
    input  logic [NUM_Q-1:0]                   cfg_half,
    input  logic [NUM_Q-1:0]                   bus_wr,
    input  logic [NUM_Q*DW-1:0]                bus_wdata,
    input  logic [NUM_Q-1:0]                   bus_rd,
    output logic [NUM_Q*DW-1:0]                bus_rdata,
    input  logic [NUM_Q-1:0]                   dp_wr,
    input  logic [NUM_Q*DW-1:0]                dp_wdata,
    input  logic [NUM_Q-1:0]                   dp_rd,
    output logic [NUM_Q*DW-1:0]                dp_rdata,
    output logic [NUM_Q-1:0]                   q_empty,
    output logic [NUM_Q-1:0]                   q_full,
    output logic [NUM_Q-1:0]                   q_has_data,
    output logic [NUM_Q-1:0]                   q_has_room,
    output logic [NUM_Q*$clog2(DEPTH+1)-1:0]   q_count,
    output logic [NUM_Q-1:0]                   q_overflow,
    output logic [NUM_Q-1:0]                   q_underflow
);

    localparam int CW = $clog2(DEPTH + 1);

    for (genvar g = 0; g < NUM_Q; g++) begin : g_lane
        lane_dir_e      dir_l;
        logic           wr_l, rd_l;
        logic [DW-1:0]  wdata_l, rdata_l;
        logic [CW-1:0]  cnt_l;

        dir_port_mux #(.DW(DW)) u_mux (
            .dir       (dir_l),
            .bus_wr    (bus_wr[g]),
            .bus_wdata (bus_wdata[g*DW +: DW]),
            .bus_rd    (bus_rd[g]),
            .dp_wr     (dp_wr[g]),
            .dp_wdata  (dp_wdata[g*DW +: DW]),
            .dp_rd     (dp_rd[g]),
            .q_rdata   (rdata_l),
            .q_wr      (wr_l),
            .q_wdata   (wdata_l),
            .q_rd      (rd_l),
            .bus_rdata (bus_rdata[g*DW +: DW]),
            .dp_rdata  (dp_rdata[g*DW +: DW])
        );

        fifo_core #(.DW(DW), .DEPTH(DEPTH)) u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_dir  (cfg_dir[g]),
            .wr       (wr_l),
            .wdata    (wdata_l),
            .rd       (rd_l),
            .dir_q    (dir_l),
            .rdata    (rdata_l),
            .cnt      (cnt_l),
            .is_empty (q_empty[g]),
            .is_full  (q_full[g]),
            .ovf      (q_overflow[g]),
            .unf      (q_underflow[g])
        );

        fifo_level_status #(.DEPTH(DEPTH)) u_lvl (
            .cnt      (cnt_l),
            .half     (cfg_half[g]),
            .has_data (q_has_data[g]),
            .has_room (q_has_room[g])
        );

        assign q_count[g*CW +: CW] = cnt_l;

        p_idle_side_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rdata[g*DW +: DW] == '0) || (dp_rdata[g*DW +: DW] == '0));
    end

endmodule

// File: tb/dual_dir_byte_fifo_tb_top.sv
module dual_dir_byte_fifo_tb_top;

    localparam int NQ = 2;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    cfg_dir, cfg_half;
    logic [1:0]    bus_wr, bus_rd, dp_wr, dp_rd;
    logic [15:0]   bus_wdata, dp_wdata;
    logic [15:0]   bus_rdata, dp_rdata;
    logic [1:0]    q_empty, q_full, q_has_data, q_has_room, q_overflow, q_underflow;
    logic [5:0]    q_count;

    int tests = 0;
    int fails = 0;

    // reference model state
    int           mc [NQ];
    int           mwp[NQ];
    int           mrp[NQ];
    logic [7:0]   mm [NQ][DEPTH];
    logic [7:0]   mrd[NQ];
    bit           movf[NQ];
    bit           munf[NQ];
    bit           md [NQ];

    always #5 clk = ~clk;

    dual_dir_byte_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_dir(cfg_dir), .cfg_half(cfg_half),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .dp_wr(dp_wr), .dp_wdata(dp_wdata), .dp_rd(dp_rd), .dp_rdata(dp_rdata),
        .q_empty(q_empty), .q_full(q_full), .q_has_data(q_has_data),
        .q_has_room(q_has_room), .q_count(q_count), .q_overflow(q_overflow),
        .q_underflow(q_underflow)
    );

    function automatic bit exp_has_data(int c, bit half);
        return c >= (half ? DEPTH / 2 : 1);
    endfunction

    function automatic bit exp_has_room(int c, bit half);
        return (DEPTH - c) >= (half ? DEPTH / 2 : 1);
    endfunction

    task automatic model_reset();
        for (int l = 0; l < NQ; l++) begin
            mc[l] = 0; mwp[l] = 0; mrp[l] = 0; mrd[l] = 8'h00;
            movf[l] = 0; munf[l] = 0; md[l] = 0;
        end
    endtask

    task automatic model_step();
        for (int l = 0; l < NQ; l++) begin
            if (cfg_dir[l] != md[l]) begin
                mc[l] = 0; mwp[l] = 0; mrp[l] = 0; mrd[l] = 8'h00;
                md[l] = cfg_dir[l];
            end else begin
                bit wr, rd, was_full, was_empty;
                logic [7:0] wd;
                wr = md[l] ? dp_wr[l] : bus_wr[l];
                rd = md[l] ? bus_rd[l] : dp_rd[l];
                wd = md[l] ? dp_wdata[l*8 +: 8] : bus_wdata[l*8 +: 8];
                was_full  = (mc[l] == DEPTH);
                was_empty = (mc[l] == 0);
                if (wr) begin
                    if (was_full) movf[l] = 1;
                    else begin
                        mm[l][mwp[l]] = wd;
                        mwp[l] = (mwp[l] + 1) % DEPTH;
                        mc[l]++;
                    end
                end
                if (rd) begin
                    if (was_empty) munf[l] = 1;
                    else begin
                        mrd[l] = mm[l][mrp[l]];
                        mrp[l] = (mrp[l] + 1) % DEPTH;
                        mc[l]--;
                    end
                end
            end
        end
    endtask

    task automatic chk(string tag, int l, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s lane%0d %s actual=%0h expected=%0h", tag, l, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int l = 0; l < NQ; l++) begin
            chk(tag, l, "count", int'(q_count[l*3 +: 3]), mc[l]);
            chk(tag, l, "empty", int'(q_empty[l]), int'(mc[l] == 0));
            chk(tag, l, "full", int'(q_full[l]), int'(mc[l] == DEPTH));
            chk(tag, l, "has_data", int'(q_has_data[l]), int'(exp_has_data(mc[l], cfg_half[l])));
            chk(tag, l, "has_room", int'(q_has_room[l]), int'(exp_has_room(mc[l], cfg_half[l])));
            chk(tag, l, "overflow", int'(q_overflow[l]), int'(movf[l]));
            chk(tag, l, "underflow", int'(q_underflow[l]), int'(munf[l]));
            chk(tag, l, "bus_rdata", int'(bus_rdata[l*8 +: 8]), md[l] ? int'(mrd[l]) : 0);
            chk(tag, l, "dp_rdata", int'(dp_rdata[l*8 +: 8]), md[l] ? 0 : int'(mrd[l]));
        end
    endtask

    task automatic idle();
        bus_wr = '0; bus_rd = '0; dp_wr = '0; dp_rd = '0;
    endtask

    // inputs already set at a falling edge; advance one cycle and check
    task automatic step(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all(tag);
        idle();
    endtask

    task automatic bus_push(int l, logic [7:0] d, string tag);
        bus_wr[l] = 1'b1; bus_wdata[l*8 +: 8] = d;
        step(tag);
    endtask

    task automatic dp_pop(int l, string tag);
        dp_rd[l] = 1'b1;
        step(tag);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'h1F2E_3D4C));
        rst_n = 1'b0;
        cfg_dir = 2'b00; cfg_half = 2'b00;
        bus_wdata = '0; dp_wdata = '0;
        idle();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;

        // R4 fill lane0 (direction 0) while lane1 stays idle (R11)
        bus_push(0, 8'h11, "R4");
        bus_push(0, 8'h22, "R4");
        bus_push(0, 8'h33, "R4");
        bus_push(0, 8'h44, "R4");
        // R5 write while full is dropped
        bus_push(0, 8'h55, "R5");
        // R2 wrong-side strobes ignored in direction 0
        dp_wr[0] = 1'b1; dp_wdata[7:0] = 8'h99; bus_rd[0] = 1'b1;
        step("R2");
        // R2 drain in order on the datapath side
        for (int i = 0; i < 4; i++) dp_pop(0, "R2");
        // R6 read while empty holds data
        dp_pop(0, "R6");

        // R7 simultaneous read and write in partial state
        bus_push(0, 8'hA1, "R7");
        bus_push(0, 8'hA2, "R7");
        bus_wr[0] = 1'b1; bus_wdata[7:0] = 8'hA3; dp_rd[0] = 1'b1;
        step("R7");
        bus_push(0, 8'hA4, "R7");
        bus_push(0, 8'hA5, "R7");
        // R8 both strobes while full
        bus_wr[0] = 1'b1; bus_wdata[7:0] = 8'hA6; dp_rd[0] = 1'b1;
        step("R8");
        for (int i = 0; i < 3; i++) dp_pop(0, "R8");
        // R8 both strobes while empty
        bus_wr[0] = 1'b1; bus_wdata[7:0] = 8'hB0; dp_rd[0] = 1'b1;
        step("R8");

        // R9 level select at half with counts 1..4
        cfg_half = 2'b11;
        step("R9");
        bus_push(0, 8'hB1, "R9");
        bus_push(0, 8'hB2, "R9");
        bus_push(0, 8'hB3, "R9");
        cfg_half = 2'b01;
        step("R9");

        // R10 direction change with data held and a strobe present
        cfg_dir[0] = 1'b1; bus_wr[0] = 1'b1; bus_wdata[7:0] = 8'hC0;
        step("R10");
        // R3 datapath writes, bus reads; R12 datapath read port stays zero
        dp_wr[0] = 1'b1; dp_wdata[7:0] = 8'hD1;
        step("R3");
        dp_wr[0] = 1'b1; dp_wdata[7:0] = 8'hD2; bus_wr[0] = 1'b1; dp_rd[0] = 1'b1;
        step("R3");
        bus_rd[0] = 1'b1;
        step("R12");
        // R11 lanes in opposite directions working in the same cycle
        bus_wr[1] = 1'b1; bus_wdata[15:8] = 8'hE1; bus_rd[0] = 1'b1;
        step("R11");
        dp_rd[1] = 1'b1; dp_wr[0] = 1'b1; dp_wdata[7:0] = 8'hE2;
        step("R11");

        // constrained random traffic
        for (int n = 0; n < 600; n++) begin
            for (int l = 0; l < NQ; l++) begin
                bus_wr[l] = ($urandom % 2) == 0;
                bus_rd[l] = ($urandom % 2) == 0;
                dp_wr[l]  = ($urandom % 2) == 0;
                dp_rd[l]  = ($urandom % 2) == 0;
                bus_wdata[l*8 +: 8] = 8'($urandom);
                dp_wdata[l*8 +: 8]  = 8'($urandom);
                if (($urandom % 40) == 0) cfg_dir[l] = ~cfg_dir[l];
                if (($urandom % 25) == 0) cfg_half[l] = ~cfg_half[l];
            end
            step(cfg_dir[0] ? "R3" : "R2");
        end

        summary();
    end

endmodule